// File: doc/BRIEF.md
# Two-Wire Bus Master Engine (single master, command driven)

This block is the master side of a two-wire serial bus, for one-to-one transfers with simple peripherals such as serial EEPROMs or converters. The host issues one command at a time: start condition, address byte, data byte out, data byte in, or stop condition. The engine runs that command on open-drain clock and data lines and raises a one-cycle completion interrupt when it is done. Start and stop conditions are produced only when the host asks for them. Nothing is added around a byte transfer.

Bus timing comes from a half-period value that the host supplies. Every phase of every command lasts that many cycles, with a floor of two. SCL is driven only from this divider. The engine does not watch for a target holding the clock low, and it does not detect arbitration loss.

A missing acknowledge after a transmitted byte sets a sticky error flag. A received byte that completes while the previous one is still unread sets a sticky overrun flag. The host clears both flags by writing ones. On reception the engine acknowledges the byte only while the host's acknowledge enable is set, so clearing that enable leaves the final byte of a read unacknowledged.

Top module: `twi_host_engine`

## Requirements
- R1: While reset is applied, and until the first command after reset, `scl_oe`, `sda_oe`, `busy`, `done_irq`, `nack_err` and `ovr_err` are 0, so both lines are released.
- R2: Command START (`cmd_op`=1) runs four phases with (SCL pulled, SDA pulled) values of (previous SCL, 0), (0,0), (0,1), (1,1). SDA therefore falls while SCL is high, and both lines are left pulled low.
- R3: Command STOP (`cmd_op`=2) runs three phases: (1,1), (0,1), (0,0). SDA therefore rises while SCL is high, and both lines are left released.
- R4: Commands ADDR (`cmd_op`=3) and WRITE (`cmd_op`=5) shift `cmd_data` out MSB first. Each bit takes a SCL-low phase then a SCL-high phase, with `sda_oe` equal to the inverted bit. For ADDR, bit 0 carries the read/write choice unchanged. A ninth clock follows with SDA released, then one SCL-low phase with SDA released: 19 phases in all.
- R5: When a transmitted byte completes, `nack_err` becomes 1 if `sda_in` was high on the last cycle of the ninth SCL-high phase.
- R6: Command RECV (`cmd_op`=4) keeps SDA released for 8 clocks and samples `sda_in` MSB first on the last cycle of each SCL-high phase. It presents the byte on `rx_data` from the completion cycle onward. The phase count is the same as in R4.
- R7: During the ninth clock of RECV, `sda_oe` equals `ack_en`. When `ack_en` is 0 the byte is left unacknowledged.
- R8: `busy` rises on the clock edge that accepts a command. `done_irq` is high for exactly one cycle, and `busy` falls in that same cycle.
- R9: A command presented while `busy` is high is ignored, and the running waveform is unchanged. When not busy, the line outputs hold their last value.
- R10: `ovr_err` becomes 1 when a RECV completes while the previous received byte has not been acknowledged by an `rx_pop` pulse.
- R11: Each phase lasts max(`half_period`,2) cycles. The value is captured when the command is accepted, and later changes to `half_period` do not affect the running command.
- R12: `nack_err` and `ovr_err` stay set until the host writes 1 to `err_clr[0]` or `err_clr[1]` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 1 start, 2 stop, 3 address, 4 receive, 5 write |
| cmd_data | input | 8 | Byte to send for address and write |
| half_period | input | HALF_W | Phase length in clock cycles (floor 2) |
| ack_en | input | 1 | Acknowledge received bytes when 1 |
| rx_pop | input | 1 | Host has read `rx_data` |
| err_clr | input | 2 | Write-one-to-clear: bit 0 no-ack flag, bit 1 overrun flag |
| sda_in | input | 1 | Data line level |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |
| busy | output | 1 | Command in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Last received byte |
| nack_err | output | 1 | Sticky missing-acknowledge flag |
| ovr_err | output | 1 | Sticky receive overrun flag |

## Verification
Take A as the clock edge that accepts a command and H as the phase length. `busy` is high after edge A, and the line levels of phase p are driven after edges A+p·H+1 through A+(p+1)·H. The completion pulse, the fall of `busy`, the error flags and `rx_data` all change on edge A+N·H for an N-phase command. The bench builds this timeline per cycle in a queue when it issues each command. It compares the lines, `busy` and `done_irq` on every falling clock edge, and it reads the flags and the received byte once the queue for the command is empty.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PH_LAST = 2 * (BYTE_W + 1);
  localparam int unsigned PH_W    = $clog2(PH_LAST + 1);
  localparam int unsigned BIT_IW  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_ADDR  = 3'd3,
    OP_RECV  = 3'd4,
    OP_WRITE = 3'd5
  } twi_op_e;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
    logic sample;
    logic last;
  } twi_drive_t;

  function automatic logic op_known(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction
endpackage

// File: rtl/twi_tick_gen.sv
module twi_tick_gen #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic [HALF_W-1:0] half_in,
  output logic              phase_end
);
  localparam logic [HALF_W-1:0] MIN_HALF = HALF_W'(2);

  logic [HALF_W-1:0] lim_q, lim_d, cnt_q, cnt_d;

  assign phase_end = run & (cnt_q == lim_q - 1'b1);

  always_comb begin
    lim_d = lim_q;
    cnt_d = cnt_q;
    if (load) begin
      lim_d = (half_in < MIN_HALF) ? MIN_HALF : half_in;
      cnt_d = '0;
    end else if (run) begin
      cnt_d = phase_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= MIN_HALF;
      cnt_q <= '0;
    end else begin
      lim_q <= lim_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/twi_phase_map.sv
module twi_phase_map
  import twi_pkg::*;
(
  input  twi_op_e           op,
  input  logic [PH_W-1:0]   ph,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              ack_en,
  input  logic              scl_hold,
  output twi_drive_t        drv
);
  localparam logic [PH_W-2:0] K_ACK = (PH_W-1)'(BYTE_W);
  localparam logic [BIT_IW-1:0] TOP_BIT = BIT_IW'(BYTE_W - 1);

  logic [PH_W-2:0] k;
  logic            hi;
  logic            rx;

  assign k  = ph[PH_W-1:1];
  assign hi = ph[0];
  assign rx = (op == OP_RECV);

  always_comb begin
    drv = '0;
    unique case (op)
      OP_START: begin
        unique case (ph)
          PH_W'(0): begin drv.scl_low = scl_hold; drv.sda_low = 1'b0; end
          PH_W'(1): begin drv.scl_low = 1'b0;     drv.sda_low = 1'b0; end
          PH_W'(2): begin drv.scl_low = 1'b0;     drv.sda_low = 1'b1; end
          default:  begin drv.scl_low = 1'b1;     drv.sda_low = 1'b1; drv.last = 1'b1; end
        endcase
      end
      OP_STOP: begin
        unique case (ph)
          PH_W'(0): begin drv.scl_low = 1'b1; drv.sda_low = 1'b1; end
          PH_W'(1): begin drv.scl_low = 1'b0; drv.sda_low = 1'b1; end
          default:  begin drv.scl_low = 1'b0; drv.sda_low = 1'b0; drv.last = 1'b1; end
        endcase
      end
      OP_ADDR, OP_WRITE, OP_RECV: begin
        if (ph == PH_W'(PH_LAST)) begin
          drv.scl_low = 1'b1;
          drv.last    = 1'b1;
        end else begin
          drv.scl_low = ~hi;
          drv.sample  = hi;
          if (k < K_ACK) begin
            drv.sda_low = rx ? 1'b0 : ~tx_byte[TOP_BIT - k[BIT_IW-1:0]];
          end else begin
            drv.sda_low = rx ? ack_en : 1'b0;
          end
        end
      end
      default: drv.last = 1'b1;
    endcase
  end
endmodule

// File: rtl/twi_flag_unit.sv
module twi_flag_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_done,
  input  logic       rx_done,
  input  logic       ack_high,
  input  logic       rx_pop,
  input  logic [1:0] err_clr,
  output logic       nack_err,
  output logic       ovr_err
);
  logic nack_q, nack_d, ovr_q, ovr_d, full_q, full_d;

  always_comb begin
    nack_d = (nack_q & ~err_clr[0]) | (tx_done & ack_high);
    ovr_d  = (ovr_q & ~err_clr[1]) | (rx_done & full_q & ~rx_pop);
    full_d = rx_done | (full_q & ~rx_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nack_q <= 1'b0;
      ovr_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      nack_q <= nack_d;
      ovr_q  <= ovr_d;
      full_q <= full_d;
    end
  end

  assign nack_err = nack_q;
  assign ovr_err  = ovr_q;
endmodule

// File: rtl/twi_host_engine.sv
module twi_host_engine
  import twi_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [7:0]        cmd_data,
  input  logic [HALF_W-1:0] half_period,
  input  logic              ack_en,
  input  logic              rx_pop,
  input  logic [1:0]        err_clr,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              done_irq,
  output logic [7:0]        rx_data,
  output logic              nack_err,
  output logic              ovr_err
);
  localparam logic [PH_W-2:0] K_ACK = (PH_W-1)'(BYTE_W);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                busy_q, busy_d;
  twi_op_e             op_q, op_d;
  logic [PH_W-1:0]     ph_q, ph_d;
  logic [BYTE_W-1:0]   sh_q, sh_d, rx_q, rx_d;
  logic                ack_q, ack_d;
  logic                scl_q, scl_d, sda_q, sda_d;
  logic                irq_q, irq_d;
  logic                accept, phase_end, fin, is_rx, is_tx;
  twi_drive_t          drv;

  assign accept = cmd_valid & ~busy_q & op_known(cmd_op);
  assign is_rx  = (op_q == OP_RECV);
  assign is_tx  = (op_q == OP_ADDR) | (op_q == OP_WRITE);
  assign fin    = busy_q & phase_end & drv.last;

  twi_tick_gen #(.HALF_W(HALF_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (busy_q),
    .load      (accept),
    .half_in   (half_period),
    .phase_end (phase_end)
  );

  twi_phase_map u_map (
    .op       (op_q),
    .ph       (ph_q),
    .tx_byte  (sh_q),
    .ack_en   (ack_en),
    .scl_hold (scl_q),
    .drv      (drv)
  );

  twi_flag_unit u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tx_done  (fin & is_tx),
    .rx_done  (fin & is_rx),
    .ack_high (ack_q),
    .rx_pop   (rx_pop),
    .err_clr  (err_clr),
    .nack_err (nack_err),
    .ovr_err  (ovr_err)
  );

  always_comb begin
    busy_d = busy_q;
    op_d   = op_q;
    ph_d   = ph_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    ack_d  = ack_q;
    scl_d  = scl_q;
    sda_d  = sda_q;
    irq_d  = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      op_d   = twi_op_e'(cmd_op);
      ph_d   = '0;
      sh_d   = cmd_data;
    end else if (busy_q) begin
      scl_d = drv.scl_low;
      sda_d = drv.sda_low;
      if (phase_end) begin
        if (drv.sample) begin
          if (ph_q[PH_W-1:1] < K_ACK) begin
            if (is_rx) sh_d = {sh_q[BYTE_W-2:0], sda_in};
          end else begin
            ack_d = sda_in;
          end
        end
        if (drv.last) begin
          busy_d = 1'b0;
          irq_d  = 1'b1;
          if (is_rx) rx_d = sh_q;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      ph_q   <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      ack_q  <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      op_q   <= op_d;
      ph_q   <= ph_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      ack_q  <= ack_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      irq_q  <= irq_d;
    end
  end

  assign scl_oe   = scl_q;
  assign sda_oe   = sda_q;
  assign busy     = busy_q;
  assign done_irq = irq_q;
  assign rx_data  = rx_q;
endmodule

// File: rtl/twi_host_engine_chk.sv
module twi_host_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done_irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       nack_err,
  input logic       ovr_err,
  input logic [1:0] err_clr
);
  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  a_r8_irq_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!busy && $past(busy)));

  a_r9_lines_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> ($stable(scl_oe) && $stable(sda_oe)));

  a_r5_nack_rises_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> done_irq);

  a_r10_ovr_rises_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> done_irq);

  a_r12_nack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nack_err) && !$past(err_clr[0])) |-> nack_err);

  a_r12_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovr_err) && !$past(err_clr[1])) |-> ovr_err);
endmodule

bind twi_host_engine twi_host_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done_irq (done_irq),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .nack_err (nack_err),
  .ovr_err  (ovr_err),
  .err_clr  (err_clr)
);

// File: tb/twi_host_engine_bench.sv
module twi_host_engine_bench;
  localparam int CLK_P = 10;
  localparam int HW    = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [7:0]    cmd_data;
  logic [HW-1:0] half_period;
  logic          ack_en;
  logic          rx_pop;
  logic [1:0]    err_clr;
  logic          sda_in;
  logic          scl_oe, sda_oe, busy, done_irq, nack_err, ovr_err;
  logic [7:0]    rx_data;

  twi_host_engine #(.HALF_W(HW)) u_twi_host_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .half_period(half_period), .ack_en(ack_en),
    .rx_pop(rx_pop), .err_clr(err_clr), .sda_in(sda_in), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .busy(busy), .done_irq(done_irq), .rx_data(rx_data),
    .nack_err(nack_err), .ovr_err(ovr_err)
  );

  always #(CLK_P/2) clk = ~clk;

  // inline target: counts SCL falls since the command was issued
  logic       tgt_rst = 1'b0;
  int         tgt_idx = 0;
  int         tgt_mode = 0;
  logic       tgt_ack = 1'b0;
  logic [7:0] tgt_byte = 8'h00;
  logic       tgt_low;
  logic       scl_line;

  assign scl_line = ~scl_oe;
  always @(negedge scl_line or posedge tgt_rst)
    if (tgt_rst) tgt_idx <= 0;
    else         tgt_idx <= tgt_idx + 1;
  always_comb
    tgt_low = (tgt_mode == 1 && tgt_idx == 8 && tgt_ack) ||
              (tgt_mode == 2 && tgt_idx < 8 && !tgt_byte[7 - (tgt_idx & 7)]);
  assign sda_in = ~(sda_oe | tgt_low);

  // reference timeline
  typedef struct packed { logic scl; logic sda; logic bsy; logic irq; } exp_t;
  exp_t  expq[$];
  logic  m_scl = 1'b0, m_sda = 1'b0;
  logic  idle_scl = 1'b0, idle_sda = 1'b0;
  string cur_req = "R1";
  int    vecs = 0;
  int    errs = 0;
  bit    done_flag = 0;

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      exp_t e;
      if (expq.size() > 0) begin
        e = expq.pop_front();
        idle_scl = e.scl;
        idle_sda = e.sda;
      end else begin
        e = '{scl: idle_scl, sda: idle_sda, bsy: 1'b0, irq: 1'b0};
      end
      vecs++;
      if ({scl_oe, sda_oe, busy, done_irq} !== {e.scl, e.sda, e.bsy, e.irq}) begin
        errs++;
        $display("FAIL %s line/busy/irq at %0t: actual %b%b%b%b expected %b%b%b%b",
                 cur_req, $time, scl_oe, sda_oe, busy, done_irq,
                 e.scl, e.sda, e.bsy, e.irq);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v,
                     input string what);
    vecs++;
    if (act !== exp_v) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
    end
  endtask

  task automatic push_ph(input logic s, input logic d, input int h);
    for (int i = 0; i < h; i++) expq.push_back('{scl: s, sda: d, bsy: 1'b1, irq: 1'b0});
    m_scl = s;
    m_sda = d;
  endtask

  task automatic build(input int op, input logic [7:0] d, input int h, input logic ae);
    expq.push_back('{scl: m_scl, sda: m_sda, bsy: 1'b1, irq: 1'b0});
    case (op)
      1: begin
        push_ph(m_scl, 1'b0, h); push_ph(1'b0, 1'b0, h);
        push_ph(1'b0, 1'b1, h);  push_ph(1'b1, 1'b1, h);
      end
      2: begin
        push_ph(1'b1, 1'b1, h); push_ph(1'b0, 1'b1, h); push_ph(1'b0, 1'b0, h);
      end
      default: begin
        for (int b = 7; b >= 0; b--) begin
          logic pull;
          pull = (op == 4) ? 1'b0 : ~d[b];
          push_ph(1'b1, pull, h);
          push_ph(1'b0, pull, h);
        end
        push_ph(1'b1, (op == 4) ? ae : 1'b0, h);
        push_ph(1'b0, (op == 4) ? ae : 1'b0, h);
        push_ph(1'b1, 1'b0, h);
      end
    endcase
    expq[expq.size()-1].bsy = 1'b0;
    expq[expq.size()-1].irq = 1'b1;
  endtask

  // probe: 0 none, 1 ignored command mid-run, 2 half_period change mid-run
  task automatic run_op(input int op, input logic [7:0] d, input int probe);
    int h;
    logic [HW-1:0] keep;
    h = (half_period < 2) ? 2 : int'(half_period);
    keep = half_period;
    @(negedge clk); #1;
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_data  = d;
    tgt_mode  = (op == 3 || op == 5) ? 1 : (op == 4) ? 2 : 0;
    tgt_rst   = 1'b1;
    build(op, d, h, ack_en);
    #1 tgt_rst = 1'b0;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    if (probe == 1) begin
      repeat (2) @(posedge clk);
      #1 cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = 8'hFF;
      @(posedge clk); #1 cmd_valid = 1'b0;
    end else if (probe == 2) begin
      half_period = HW'(7);
    end
    wait (expq.size() == 0);
    #1;
    half_period = keep;
  endtask

  task automatic pulse_in(input logic pop, input logic [1:0] clr);
    @(negedge clk); #1;
    rx_pop  = pop;
    err_clr = clr;
    @(posedge clk); #1;
    rx_pop  = 1'b0;
    err_clr = 2'b00;
  endtask

  task automatic finish_up;
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = 8'h00;
    half_period = HW'(3); ack_en = 1'b1; rx_pop = 1'b0; err_clr = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", {2'b00, scl_oe, sda_oe, busy, done_irq, nack_err, ovr_err}, 8'h00, "outputs in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", {2'b00, scl_oe, sda_oe, busy, done_irq, nack_err, ovr_err}, 8'h00, "outputs after release");

    cur_req = "R2"; run_op(1, 8'h00, 0);
    cur_req = "R4"; tgt_ack = 1'b1; run_op(3, 8'hA0, 0);
    chk("R5", {7'd0, nack_err}, 8'h00, "no-ack flag after acked address");
    run_op(5, 8'h5C, 0);
    chk("R5", {7'd0, nack_err}, 8'h00, "no-ack flag after acked write");
    cur_req = "R5"; tgt_ack = 1'b0; run_op(5, 8'h3F, 0);
    chk("R5", {7'd0, nack_err}, 8'h01, "no-ack flag after missing ack");
    cur_req = "R12"; tgt_ack = 1'b1; run_op(5, 8'h11, 0);
    chk("R12", {7'd0, nack_err}, 8'h01, "no-ack flag stays set");
    pulse_in(1'b0, 2'b01);
    chk("R12", {7'd0, nack_err}, 8'h00, "no-ack flag cleared");

    cur_req = "R11"; half_period = HW'(1); run_op(5, 8'h96, 2);
    cur_req = "R3";  half_period = HW'(2); run_op(2, 8'h00, 0);

    cur_req = "R2"; run_op(1, 8'h00, 0);
    cur_req = "R4"; run_op(3, 8'hA1, 0);
    cur_req = "R6"; ack_en = 1'b1; tgt_byte = 8'hC6; run_op(4, 8'h00, 0);
    chk("R6", rx_data, 8'hC6, "received byte");
    chk("R10", {7'd0, ovr_err}, 8'h00, "overrun after first byte");
    cur_req = "R7"; ack_en = 1'b0; tgt_byte = 8'h39; run_op(4, 8'h00, 0);
    chk("R6", rx_data, 8'h39, "received byte, no ack");
    chk("R10", {7'd0, ovr_err}, 8'h01, "overrun on unread byte");
    pulse_in(1'b1, 2'b10);
    chk("R12", {7'd0, ovr_err}, 8'h00, "overrun cleared");
    cur_req = "R10"; ack_en = 1'b1; tgt_byte = 8'h81; run_op(4, 8'h00, 0);
    chk("R10", {7'd0, ovr_err}, 8'h00, "no overrun after pop");
    chk("R6", rx_data, 8'h81, "received byte after pop");
    cur_req = "R9"; run_op(2, 8'h00, 1);
    repeat (6) @(posedge clk);
    #1;
    chk("R9", {6'd0, busy, done_irq}, 8'h00, "ignored command left engine idle");
    chk("R3", {6'd0, scl_oe, sda_oe}, 8'h00, "lines released after stop");
    finish_up();
  end
endmodule